// File: doc/BRIEF.md
# Configurable Pixel Component Extractor

This block sits between the pixel fetch path and the display output of a raster scan engine. Each clock it takes one packed framebuffer word and produces an 8-bit red, green and blue value. Software describes the pixel layout with one format word and three channel-select words. The format word says how many bytes of the incoming word belong to the pixel. Each select word gives the position of the lowest bit of that channel's field, the width of the field, and a fallback colour value.

A field narrower than eight bits is widened by placing it at the top of the output and repeating its upper bits downward, so full-scale input maps to 0xFF. A field wider than eight bits keeps its most significant eight bits. The fallback value replaces a channel whenever its width is programmed to zero, whenever the timing path marks the pixel as outside the active area, and whenever the fetch path reports starvation. Setting red's fallback to 0xFF makes starved pixels show up as red during bring-up.

The result is registered, so the three component outputs follow the sampled inputs by exactly one clock.

Top module: `pix_comp_extract`

## Requirements
- R1: While rst_n is low, all three component outputs are 0x00.
- R2: Each output value is computed from the inputs sampled at the previous rising clock edge, which gives one cycle of latency.
- R3: For each channel, select bits 4:0 give the lowest extracted bit and select bits 11:8 give the field length. The field is word bits [offset+length-1 : offset]. Any position at or above bit 32 reads as zero.
- R4: A field length of 8 passes the field to the output unchanged.
- R5: A field length of 1 to 7 is placed at the top of the output, and its bits are repeated from the top down into the lower positions. For example, length 5 with value abcde gives abcdeabc.
- R6: A field length of 9 to 15 outputs the top eight bits of the field.
- R7: Format bits 4:3 hold the number of pixel bytes minus one. Word bytes at or above that count are treated as zero before extraction.
- R8: A field length of 0 outputs the channel's fallback value from select bits 23:16.
- R9: When de is low, every channel outputs its fallback value.
- R10: When underrun is high, every channel outputs its fallback value.
- R11: When pix_valid is low, every channel outputs its fallback value.
- R12: Each channel uses only its own select word, so the three channels can have different layouts at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fmt_cfg | input | 32 | Format word; bits 4:3 = bytes per pixel minus one |
| sel_red | input | 32 | Red select: fallback 23:16, length 11:8, offset 4:0 |
| sel_green | input | 32 | Green select, same layout |
| sel_blue | input | 32 | Blue select, same layout |
| pix_word | input | 32 | Packed pixel word from the fetch path |
| pix_valid | input | 1 | Pixel word holds data |
| de | input | 1 | Active-area flag from the timing path |
| underrun | input | 1 | Fetch starvation flag |
| red_o | output | 8 | Red component |
| green_o | output | 8 | Green component |
| blue_o | output | 8 | Blue component |

## Verification
The hardest cases to reach come from combining inputs. The pixel-byte mask must cut a field in the middle, and offsets near the top of the word must push part of the field past bit 31. Both have to coincide with lengths that need bit repetition or truncation. Directed steps place short and long fields across the byte-mask boundary and at offset 28 and above. A long random phase then drives all three channels with unrelated select words, formats and flag patterns every cycle, and a behavioural model checks each output.

// File: rtl/pce_pkg.sv
package pce_pkg;
    localparam int SEL_OFS_LSB = 0;
    localparam int SEL_OFS_W   = 5;
    localparam int SEL_LEN_LSB = 8;
    localparam int SEL_LEN_W   = 4;
    localparam int SEL_DEF_LSB = 16;
    localparam int FMT_BPP_LSB = 3;

    typedef enum int {CH_RED = 0, CH_GREEN = 1, CH_BLUE = 2} chan_e;
    localparam int NUM_CH = 3;
endpackage

// File: rtl/pce_byte_mask.sv
module pce_byte_mask #(
    parameter int PIX_BYTES = 4,
    parameter int BPP_W     = 2
) (
    input  logic [PIX_BYTES*8-1:0] word_i,
    input  logic [BPP_W-1:0]       bpp_m1_i,
    output logic [PIX_BYTES*8-1:0] word_o
);
    for (genvar b = 0; b < PIX_BYTES; b++) begin : g_byte
        assign word_o[b*8 +: 8] = (bpp_m1_i >= BPP_W'(b)) ? word_i[b*8 +: 8] : 8'h00;
    end
endmodule

// File: rtl/pce_lane.sv
module pce_lane import pce_pkg::*; #(
    parameter int PIX_W  = 32,
    parameter int COMP_W = 8
) (
    input  logic [PIX_W-1:0]     word_i,
    input  logic [SEL_OFS_W-1:0] ofs_i,
    input  logic [SEL_LEN_W-1:0] len_i,
    input  logic [COMP_W-1:0]    dflt_i,
    input  logic                 force_dflt_i,
    output logic [COMP_W-1:0]    comp_o
);
    localparam int IDX_W = $clog2(PIX_W);

    logic [PIX_W-1:0]  shifted;
    logic [COMP_W-1:0] scaled;
    int                len_int;
    int                pos;

    always_comb begin
        shifted = word_i >> ofs_i;
        len_int = int'(len_i);
        scaled  = '0;
        pos     = 0;
        // Output bit k (counted from the MSB) takes field bit len-1-(k mod len).
        for (int k = 0; k < COMP_W; k++) begin
            if (len_int != 0) begin
                pos = len_int - 1 - (k % len_int);
                scaled[COMP_W-1-k] = shifted[pos[IDX_W-1:0]];
            end
        end
        comp_o = (force_dflt_i || len_i == '0) ? dflt_i : scaled;
    end
endmodule

// File: rtl/pix_comp_extract.sv
module pix_comp_extract import pce_pkg::*; #(
    parameter int PIX_BYTES = 4,
    parameter int COMP_W    = 8,
    parameter int CFG_W     = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CFG_W-1:0] fmt_cfg,
    input  logic [CFG_W-1:0] sel_red,
    input  logic [CFG_W-1:0] sel_green,
    input  logic [CFG_W-1:0] sel_blue,
    input  logic [PIX_BYTES*8-1:0] pix_word,
    input  logic             pix_valid,
    input  logic             de,
    input  logic             underrun,
    output logic [COMP_W-1:0] red_o,
    output logic [COMP_W-1:0] green_o,
    output logic [COMP_W-1:0] blue_o
);
    localparam int PIX_W = PIX_BYTES * 8;
    localparam int BPP_W = (PIX_BYTES > 1) ? $clog2(PIX_BYTES) : 1;

    typedef struct packed {
        logic [NUM_CH-1:0][COMP_W-1:0] comp;
    } state_t;

    state_t st_d, st_q;

    logic [NUM_CH-1:0][CFG_W-1:0]  sel_all;
    logic [NUM_CH-1:0][COMP_W-1:0] lane_comp;
    logic [PIX_W-1:0]              word_masked;
    logic                          use_dflt;

    assign sel_all[CH_RED]   = sel_red;
    assign sel_all[CH_GREEN] = sel_green;
    assign sel_all[CH_BLUE]  = sel_blue;
    assign use_dflt = !de || underrun || !pix_valid;

    pce_byte_mask #(.PIX_BYTES(PIX_BYTES), .BPP_W(BPP_W)) u_mask (
        .word_i   (pix_word),
        .bpp_m1_i (fmt_cfg[FMT_BPP_LSB +: BPP_W]),
        .word_o   (word_masked)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_lane
        pce_lane #(.PIX_W(PIX_W), .COMP_W(COMP_W)) u_lane (
            .word_i       (word_masked),
            .ofs_i        (sel_all[c][SEL_OFS_LSB +: SEL_OFS_W]),
            .len_i        (sel_all[c][SEL_LEN_LSB +: SEL_LEN_W]),
            .dflt_i       (sel_all[c][SEL_DEF_LSB +: COMP_W]),
            .force_dflt_i (use_dflt),
            .comp_o       (lane_comp[c])
        );
    end

    always_comb begin
        st_d = st_q;
        for (int c = 0; c < NUM_CH; c++) begin
            st_d.comp[c] = lane_comp[c];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign red_o   = st_q.comp[CH_RED];
    assign green_o = st_q.comp[CH_GREEN];
    assign blue_o  = st_q.comp[CH_BLUE];
endmodule

// File: rtl/pce_checker.sv
module pce_checker #(
    parameter int PIX_W  = 32,
    parameter int COMP_W = 8,
    parameter int CFG_W  = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [CFG_W-1:0]  sel_red,
    input logic [CFG_W-1:0]  sel_green,
    input logic [CFG_W-1:0]  sel_blue,
    input logic [PIX_W-1:0]  pix_word,
    input logic              pix_valid,
    input logic              de,
    input logic              underrun,
    input logic [COMP_W-1:0] red_o,
    input logic [COMP_W-1:0] green_o,
    input logic [COMP_W-1:0] blue_o
);
    assert_reset_zero_R1: assert property (@(posedge clk)
        !rst_n |=> (red_o == '0 && green_o == '0 && blue_o == '0));

    assert_blank_dflt_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !de |=> (red_o == $past(sel_red[23:16]) && green_o == $past(sel_green[23:16])
                 && blue_o == $past(sel_blue[23:16])));

    assert_underrun_dflt_R10: assert property (@(posedge clk) disable iff (!rst_n)
        underrun |=> (red_o == $past(sel_red[23:16]) && green_o == $past(sel_green[23:16])
                      && blue_o == $past(sel_blue[23:16])));

    assert_starve_dflt_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !pix_valid |=> (red_o == $past(sel_red[23:16]) && green_o == $past(sel_green[23:16])
                        && blue_o == $past(sel_blue[23:16])));

    assert_zero_len_dflt_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_green[11:8] == 4'd0) |=> (green_o == $past(sel_green[23:16])));

    assert_byte0_pass_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (de && pix_valid && !underrun && sel_red[11:8] == 4'd8 && sel_red[4:0] == 5'd0)
        |=> (red_o == $past(pix_word[7:0])));
endmodule

bind pix_comp_extract pce_checker #(.PIX_W(PIX_BYTES*8), .COMP_W(COMP_W), .CFG_W(CFG_W)) u_pce_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sel_red   (sel_red),
    .sel_green (sel_green),
    .sel_blue  (sel_blue),
    .pix_word  (pix_word),
    .pix_valid (pix_valid),
    .de        (de),
    .underrun  (underrun),
    .red_o     (red_o),
    .green_o   (green_o),
    .blue_o    (blue_o)
);

// File: tb/pix_comp_extract_bench.sv
module pix_comp_extract_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] fmt_cfg = '0, sel_red = '0, sel_green = '0, sel_blue = '0, pix_word = '0;
    logic        pix_valid = 1'b0, de = 1'b0, underrun = 1'b0;
    logic [7:0]  red_o, green_o, blue_o;

    int compared = 0;
    int mismatched = 0;
    logic [7:0] exp_r = '0, exp_g = '0, exp_b = '0;
    string      exp_tag = "R1";
    bit         done = 1'b0;

    always #2 clk = ~clk;

    pix_comp_extract u_pix_comp_extract (
        .clk(clk), .rst_n(rst_n), .fmt_cfg(fmt_cfg),
        .sel_red(sel_red), .sel_green(sel_green), .sel_blue(sel_blue),
        .pix_word(pix_word), .pix_valid(pix_valid), .de(de), .underrun(underrun),
        .red_o(red_o), .green_o(green_o), .blue_o(blue_o)
    );

    function automatic logic [7:0] model(logic [31:0] fmt, logic [31:0] sel, logic [31:0] word,
                                         logic v, logic d, logic u);
        int len = int'(sel[11:8]);
        int ofs = int'(sel[4:0]);
        int nbits = (int'(fmt[4:3]) + 1) * 8;
        longint field = 0;
        longint acc;
        int n;
        if (!d || u || !v || len == 0) return sel[23:16];
        for (int i = 0; i < len; i++) begin
            if (ofs + i < nbits && ofs + i < 32 && word[ofs + i]) field = field | (longint'(1) << i);
        end
        acc = field;
        n = len;
        while (n < 8) begin
            acc = (acc << len) | field;
            n = n + len;
        end
        return 8'(acc >> (n - 8));
    endfunction

    function automatic logic [31:0] mk_sel(int dflt, int len, int ofs);
        return (32'(dflt) << 16) | (32'(len) << 8) | 32'(ofs);
    endfunction

    task automatic cmp(string ch, logic [7:0] act, logic [7:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s %s: actual %h expected %h", exp_tag, ch, act, exp);
        end
    endtask

    task automatic step(string tag, logic rst, logic [31:0] f, logic [31:0] sr, logic [31:0] sg,
                        logic [31:0] sb, logic [31:0] w, logic v, logic d, logic u);
        @(negedge clk);
        cmp("red", red_o, exp_r);
        cmp("green", green_o, exp_g);
        cmp("blue", blue_o, exp_b);
        rst_n = rst; fmt_cfg = f; sel_red = sr; sel_green = sg; sel_blue = sb;
        pix_word = w; pix_valid = v; de = d; underrun = u;
        exp_tag = tag;
        if (!rst) begin
            exp_r = '0; exp_g = '0; exp_b = '0;
        end else begin
            exp_r = model(f, sr, w, v, d, u);
            exp_g = model(f, sg, w, v, d, u);
            exp_b = model(f, sb, w, v, d, u);
        end
    endtask

    initial begin
        // R1: reset holds outputs at zero even with live inputs
        step("R1", 1'b0, 32'h18, mk_sel(8'h11, 8, 0), mk_sel(8'h22, 8, 8), mk_sel(8'h33, 8, 16),
             32'hA5C3_7E19, 1, 1, 0);
        step("R1", 1'b0, 32'h18, mk_sel(8'h11, 8, 0), mk_sel(8'h22, 8, 8), mk_sel(8'h33, 8, 16),
             32'hFFFF_FFFF, 1, 1, 0);
        // R4: 8-bit fields, 4-byte pixel
        step("R4", 1'b1, 32'h18, mk_sel(0, 8, 16), mk_sel(0, 8, 8), mk_sel(0, 8, 0),
             32'h00A1_B2C3, 1, 1, 0);
        step("R2", 1'b1, 32'h18, mk_sel(0, 8, 16), mk_sel(0, 8, 8), mk_sel(0, 8, 0),
             32'h0012_3456, 1, 1, 0);
        // R5: short fields (RGB565-style and length 1 / 3)
        step("R5", 1'b1, 32'h08, mk_sel(0, 5, 11), mk_sel(0, 6, 5), mk_sel(0, 5, 0),
             32'h0000_F81F, 1, 1, 0);
        step("R5", 1'b1, 32'h08, mk_sel(0, 5, 11), mk_sel(0, 6, 5), mk_sel(0, 5, 0),
             32'h0000_A5B6, 1, 1, 0);
        step("R5", 1'b1, 32'h18, mk_sel(0, 1, 3), mk_sel(0, 3, 0), mk_sel(0, 7, 9),
             32'h0000_BEEF, 1, 1, 0);
        // R6: long fields
        step("R6", 1'b1, 32'h18, mk_sel(0, 12, 4), mk_sel(0, 15, 17), mk_sel(0, 9, 0),
             32'h9ABC_DEF1, 1, 1, 0);
        // R3: offsets near the top, field past bit 31
        step("R3", 1'b1, 32'h18, mk_sel(0, 8, 28), mk_sel(0, 4, 30), mk_sel(0, 8, 31),
             32'hF000_0000, 1, 1, 0);
        // R7: byte mask cuts fields
        step("R7", 1'b1, 32'h00, mk_sel(0, 8, 8), mk_sel(0, 8, 4), mk_sel(0, 8, 0),
             32'hFFFF_FFFF, 1, 1, 0);
        step("R7", 1'b1, 32'h10, mk_sel(0, 8, 16), mk_sel(0, 8, 20), mk_sel(0, 5, 10),
             32'hFFFF_FFFF, 1, 1, 0);
        // R8: zero length gives fallback
        step("R8", 1'b1, 32'h18, mk_sel(8'hFF, 0, 0), mk_sel(8'h5A, 8, 0), mk_sel(8'h3C, 0, 8),
             32'h1234_5678, 1, 1, 0);
        // R9: blanking
        step("R9", 1'b1, 32'h18, mk_sel(8'h12, 8, 0), mk_sel(8'h34, 8, 8), mk_sel(8'h56, 8, 16),
             32'hFFFF_FFFF, 1, 0, 0);
        // R10: underrun shows red
        step("R10", 1'b1, 32'h18, mk_sel(8'hFF, 8, 0), mk_sel(8'h00, 8, 8), mk_sel(8'h00, 8, 16),
             32'h0055_AA33, 1, 1, 1);
        // R11: no valid word
        step("R11", 1'b1, 32'h18, mk_sel(8'h81, 8, 0), mk_sel(8'h42, 8, 8), mk_sel(8'h24, 8, 16),
             32'h0055_AA33, 0, 1, 0);
        step("R2", 1'b1, 32'h18, mk_sel(8'h81, 8, 0), mk_sel(8'h42, 8, 8), mk_sel(8'h24, 8, 16),
             32'h0055_AA33, 1, 1, 0);
        // R12: independent random channel layouts with mixed flags
        for (int i = 0; i < 400; i++) begin
            step("R12", 1'b1, $urandom, $urandom, $urandom, $urandom, $urandom,
                 ($urandom % 8) != 0, ($urandom % 6) != 0, ($urandom % 10) == 0);
        end
        // R1: reset again mid-stream
        step("R1", 1'b0, 32'h18, mk_sel(8'h11, 8, 0), mk_sel(8'h22, 8, 8), mk_sel(8'h33, 8, 16),
             32'h1234_5678, 1, 1, 0);
        step("R1", 1'b1, 32'h18, mk_sel(8'h11, 8, 0), mk_sel(8'h22, 8, 8), mk_sel(8'h33, 8, 16),
             32'h1234_5678, 1, 1, 0);
        step("R2", 1'b1, 32'h18, 0, 0, 0, 0, 1, 1, 0);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            compared++;
            mismatched++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end
endmodule